// File: doc/BRIEF.md
# Processor Exception Dispatch Controller

This block collects the exception requests of a simple in-order core and decides, cycle by cycle, which one is taken and when. For the winning cause it raises a one-cycle take strobe, drives the handler vector offset, copies the restart address and the current machine-state bits into two save registers, and updates the live state bits. The pipeline, the handlers and memory management are outside the block. Instruction progress reaches it as two status levels: one says an instruction is in execution, the other says that instruction completes this cycle.

Causes fall into three classes. System reset and machine check are non-maskable and are taken regardless of instruction progress. Data and instruction access faults are synchronous and precise and belong to the instruction in flight. External and decrementer interrupts are maskable and asynchronous: they are taken only in a cycle where no instruction is executing or the executing one completes. A machine check that arrives while machine checks are disabled stops the controller instead of dispatching. All control pins are plain levels. There is no streamed data path, so no valid/ready handshake exists.

Top module: `exc_dispatch`

## Requirements
- R1: While `rst_n` is low, `take_exc`, `checkstop` and `cur_state` are 0. At the first rising clock edge after release, a power-on reset is taken: `take_exc` is 1 for one cycle with `vec_off` = 0x00100.
- R2: `hard_rst_req` or `soft_rst_req` is taken at once, even while an instruction is busy, with vector 0x00100. It clears all state bits and clears `checkstop`.
- R3: A machine check is requested by `mchk_pin`, by any of the three parity error flags, or by `bus_err_ack` while `data_xfer_act` is 1. With the machine-check enable bit set, it is taken with vector 0x00200. The external enable and recoverable bits are cleared and the machine-check enable bit is kept. `bus_err_ack` alone requests nothing.
- R4: A machine-check request while the machine-check enable bit is 0 produces no take. It sets `checkstop`, which stays set and blocks every cause except reset until a reset is taken.
- R5: A data access fault is taken with vector 0x00300 and an instruction access fault with vector 0x00400, whether or not an instruction is busy. The external enable bit is cleared and the other state bits are kept.
- R6: `ext_irq` is taken with vector 0x00500 only while the external enable bit is 1.
- R7: `dec_irq` is taken with vector 0x00900 only while the external enable bit is 1.
- R8: A maskable request is taken only in a cycle where `insn_busy` is 0 or `insn_done` is 1.
- R9: Fixed priority, highest first: reset, machine check, data fault, instruction fault, external, decrementer. Exactly one cause is taken per strobe.
- R10: On a take, `saved_pc` holds the `restart_pc` of the deciding cycle and `saved_state` holds the state bits as they stood before the take.
- R11: Maskable requests are level-sensitive. A request withdrawn before its window opens is never taken.
- R12: `state_load` copies `state_in` into the state bits in a cycle with no take. In a take cycle the take's update wins and `state_in` is ignored.
- R13: `vec_off` is never 0x00000 while `take_exc` is 1.

State bit encoding for `state_in`, `saved_state` and `cur_state`: bit 2 is external enable, bit 1 is machine-check enable, bit 0 is recoverable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| hard_rst_req | input | 1 | Hard reset request |
| soft_rst_req | input | 1 | Soft reset request |
| mchk_pin | input | 1 | Machine-check pin |
| bus_err_ack | input | 1 | Transfer-error acknowledge |
| data_xfer_act | input | 1 | Data bus transfer in progress |
| addr_par_err | input | 1 | Address bus parity error |
| data_par_err | input | 1 | Data bus parity error |
| l2_par_err | input | 1 | Second-level cache bus parity error |
| dacc_fault | input | 1 | Data access fault of the instruction in flight |
| iacc_fault | input | 1 | Instruction access fault |
| ext_irq | input | 1 | External interrupt level |
| dec_irq | input | 1 | Decrementer interrupt level |
| insn_busy | input | 1 | An instruction is in execution |
| insn_done | input | 1 | The executing instruction completes this cycle |
| restart_pc | input | AW | Restart address for the current cycle |
| state_load | input | 1 | Load `state_in` into the state bits |
| state_in | input | 3 | State bits to load |
| take_exc | output | 1 | One-cycle take strobe |
| vec_off | output | VW | Vector offset of the taken cause |
| saved_pc | output | AW | Saved restart address |
| saved_state | output | 3 | Saved state bits |
| cur_state | output | 3 | Live state bits |
| checkstop | output | 1 | Halted after a disabled machine check |

## Verification
The assertions assume that the fault, interrupt and reset levels are settled before each rising edge. They also assume that `insn_done` is only meaningful together with `insn_busy` and that `state_in` uses the stated bit encoding. The stimulus changes every input on the falling edge and holds it through the next rising edge. It loads the state bits in a request-free cycle before each table row, so every assertion sees a known state when it fires. Completion is asserted only alongside busy.

// File: rtl/exc_pkg.sv
`timescale 1ns/1ps
package exc_pkg;
  typedef struct packed {
    logic ee;   // external/decrementer enable
    logic me;   // machine-check enable
    logic ri;   // recoverable
  } mstate_t;

  localparam int NCAUSE = 6;
  localparam int CW     = $clog2(NCAUSE);

  // index order is priority order, 0 highest
  typedef enum logic [CW-1:0] {
    CZ_RST  = 3'd0,
    CZ_MC   = 3'd1,
    CZ_DFLT = 3'd2,
    CZ_IFLT = 3'd3,
    CZ_EXT  = 3'd4,
    CZ_DEC  = 3'd5
  } cause_e;
endpackage

// File: rtl/exc_gather.sv
`timescale 1ns/1ps
module exc_gather
  import exc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              por_pend,
  input  logic              hard_rst,
  input  logic              soft_rst,
  input  logic              mc_pin,
  input  logic              tea,
  input  logic              dbus_act,
  input  logic              ap_err,
  input  logic              dp_err,
  input  logic              l2_err,
  input  logic              dfault,
  input  logic              ifault,
  input  logic              ext,
  input  logic              dec,
  input  logic              busy,
  input  logic              done,
  input  logic              halted,
  input  mstate_t           st,
  output logic [NCAUSE-1:0] req,
  output logic              mc_stop
);
  logic rst_any, mc_raw, blk, win;

  always_comb begin
    rst_any = por_pend | hard_rst | soft_rst;
    mc_raw  = mc_pin | (tea & dbus_act) | ap_err | dp_err | l2_err;
    blk     = halted | (mc_raw & ~st.me);
    win     = ~busy | done;
    req              = '0;
    req[CZ_RST]      = rst_any;
    req[CZ_MC]       = mc_raw & st.me & ~halted;
    req[CZ_DFLT]     = dfault & ~blk;
    req[CZ_IFLT]     = ifault & ~blk;
    req[CZ_EXT]      = ext & st.ee & win & ~blk;
    req[CZ_DEC]      = dec & st.ee & win & ~blk;
    mc_stop          = mc_raw & ~st.me & ~halted & ~rst_any;
  end

  // R4
  stop_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mc_stop |-> (req == '0));
  // R8
  mask_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req[CZ_EXT] | req[CZ_DEC]) |-> (!busy || done));
endmodule

// File: rtl/exc_arbiter.sv
`timescale 1ns/1ps
module exc_arbiter #(
  parameter int N  = 6,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);
  for (genvar i = 0; i < N; i++) begin : g_pick
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_low
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end

  assign any = |req;

  // R9
  one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (any == (grant != '0)));
  // R9
  grant_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]);
endmodule

// File: rtl/exc_state_save.sv
`timescale 1ns/1ps
module exc_state_save
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 20,
  parameter logic [VW-1:0] V_RST  = 20'h00100,
  parameter logic [VW-1:0] V_MC   = 20'h00200,
  parameter logic [VW-1:0] V_DFLT = 20'h00300,
  parameter logic [VW-1:0] V_IFLT = 20'h00400,
  parameter logic [VW-1:0] V_EXT  = 20'h00500,
  parameter logic [VW-1:0] V_DEC  = 20'h00900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  cause_e        cause,
  input  logic          mc_stop,
  input  logic [AW-1:0] pc,
  input  logic          ld,
  input  mstate_t       ld_val,
  output logic          take_q,
  output logic [VW-1:0] vec_q,
  output logic [AW-1:0] srr_pc,
  output mstate_t       srr_st,
  output mstate_t       cur,
  output logic          halted,
  output logic          por_pend
);
  mstate_t          nxt;
  logic [VW-1:0]    vsel;

  always_comb begin
    case (cause)
      CZ_RST:  vsel = V_RST;
      CZ_MC:   vsel = V_MC;
      CZ_DFLT: vsel = V_DFLT;
      CZ_IFLT: vsel = V_IFLT;
      CZ_EXT:  vsel = V_EXT;
      default: vsel = V_DEC;
    endcase
  end

  always_comb begin
    nxt = cur;
    if (take) begin
      case (cause)
        CZ_RST:  nxt = '0;
        CZ_MC:   nxt = '{ee: 1'b0, me: cur.me, ri: 1'b0};
        default: nxt = '{ee: 1'b0, me: cur.me, ri: cur.ri};
      endcase
    end else if (ld) begin
      nxt = ld_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q   <= 1'b0;
      vec_q    <= '0;
      srr_pc   <= '0;
      srr_st   <= '0;
      cur      <= '0;
      halted   <= 1'b0;
      por_pend <= 1'b1;
    end else begin
      take_q <= take;
      cur    <= nxt;
      if (take) begin
        vec_q  <= vsel;
        srr_pc <= pc;
        srr_st <= cur;
      end
      if (take && cause == CZ_RST) begin
        halted   <= 1'b0;
        por_pend <= 1'b0;
      end else if (mc_stop) begin
        halted <= 1'b1;
      end
    end
  end

  // R10
  save_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> srr_st == $past(cur));
  // R5
  ee_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_q |-> !cur.ee);
  // R2
  reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_q && vec_q == V_RST) |-> (cur == '0 && !halted));
  // R4
  halt_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !take_q);
endmodule

// File: rtl/exc_dispatch.sv
`timescale 1ns/1ps
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int AW = 32,
  parameter int VW = 20,
  parameter logic [VW-1:0] V_EXT = 20'h00500,
  parameter logic [VW-1:0] V_DEC = 20'h00900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hard_rst_req,
  input  logic          soft_rst_req,
  input  logic          mchk_pin,
  input  logic          bus_err_ack,
  input  logic          data_xfer_act,
  input  logic          addr_par_err,
  input  logic          data_par_err,
  input  logic          l2_par_err,
  input  logic          dacc_fault,
  input  logic          iacc_fault,
  input  logic          ext_irq,
  input  logic          dec_irq,
  input  logic          insn_busy,
  input  logic          insn_done,
  input  logic [AW-1:0] restart_pc,
  input  logic          state_load,
  input  logic [2:0]    state_in,
  output logic          take_exc,
  output logic [VW-1:0] vec_off,
  output logic [AW-1:0] saved_pc,
  output logic [2:0]    saved_state,
  output logic [2:0]    cur_state,
  output logic          checkstop
);
  logic [NCAUSE-1:0] req, grant;
  logic [CW-1:0]     idx;
  logic              any, mc_stop, por_pend;
  mstate_t           st, srr_st;

  exc_gather u_gather (
    .clk(clk), .rst_n(rst_n), .por_pend(por_pend),
    .hard_rst(hard_rst_req), .soft_rst(soft_rst_req),
    .mc_pin(mchk_pin), .tea(bus_err_ack), .dbus_act(data_xfer_act),
    .ap_err(addr_par_err), .dp_err(data_par_err), .l2_err(l2_par_err),
    .dfault(dacc_fault), .ifault(iacc_fault), .ext(ext_irq), .dec(dec_irq),
    .busy(insn_busy), .done(insn_done), .halted(checkstop), .st(st),
    .req(req), .mc_stop(mc_stop)
  );

  exc_arbiter #(.N(NCAUSE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req),
    .grant(grant), .idx(idx), .any(any)
  );

  exc_state_save #(.AW(AW), .VW(VW), .V_EXT(V_EXT), .V_DEC(V_DEC)) u_save (
    .clk(clk), .rst_n(rst_n), .take(any), .cause(cause_e'(idx)),
    .mc_stop(mc_stop), .pc(restart_pc), .ld(state_load),
    .ld_val(mstate_t'(state_in)),
    .take_q(take_exc), .vec_q(vec_off), .srr_pc(saved_pc),
    .srr_st(srr_st), .cur(st), .halted(checkstop), .por_pend(por_pend)
  );

  assign saved_state = srr_st;
  assign cur_state   = st;

  // R13
  no_zero_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> vec_off != '0);
  // R6
  ext_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && (vec_off == V_EXT || vec_off == V_DEC)) |-> $past(st.ee));
  // R8
  ext_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_exc && (vec_off == V_EXT || vec_off == V_DEC))
      |-> $past(!insn_busy || insn_done));
  // R10
  saved_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_exc |-> saved_pc == $past(restart_pc));
endmodule

// File: tb/sim_exc_dispatch.sv
`timescale 1ns/1ps
module sim_exc_dispatch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hrst, srst, mc, tea, dba, ap, dp, l2p, dfl, ifl, ext, dec, busy, done;
  logic [31:0] pc;
  logic        sld;
  logic [2:0]  sin;
  logic        take;
  logic [19:0] vec;
  logic [31:0] spc;
  logic [2:0]  sst, cst;
  logic        cstop;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2 clk = ~clk;

  exc_dispatch u0 (
    .clk(clk), .rst_n(rst_n), .hard_rst_req(hrst), .soft_rst_req(srst),
    .mchk_pin(mc), .bus_err_ack(tea), .data_xfer_act(dba),
    .addr_par_err(ap), .data_par_err(dp), .l2_par_err(l2p),
    .dacc_fault(dfl), .iacc_fault(ifl), .ext_irq(ext), .dec_irq(dec),
    .insn_busy(busy), .insn_done(done), .restart_pc(pc),
    .state_load(sld), .state_in(sin), .take_exc(take), .vec_off(vec),
    .saved_pc(spc), .saved_state(sst), .cur_state(cst), .checkstop(cstop)
  );

  // input bits: 13 hrst 12 srst 11 mc 10 tea 9 dba 8 ap 7 dp 6 l2p
  //             5 dfl 4 ifl 3 ext 2 dec 1 busy 0 done
  typedef struct packed {
    logic [2:0]  st;
    logic [13:0] rin;
    logic        tk;
    logic [19:0] v;
    logic [2:0]  nst;
  } row_t;

  localparam int NROW = 18;
  localparam row_t TBL [NROW] = '{
    '{3'b111, 14'b00000000001000, 1'b1, 20'h00500, 3'b011}, // R6
    '{3'b011, 14'b00000000001000, 1'b0, 20'h00000, 3'b011}, // R6 masked
    '{3'b111, 14'b00000000001010, 1'b0, 20'h00000, 3'b111}, // R8 busy
    '{3'b111, 14'b00000000001011, 1'b1, 20'h00500, 3'b011}, // R8 done
    '{3'b111, 14'b00000000000100, 1'b1, 20'h00900, 3'b011}, // R7
    '{3'b111, 14'b00000000001100, 1'b1, 20'h00500, 3'b011}, // R9 ext>dec
    '{3'b101, 14'b00000000100010, 1'b1, 20'h00300, 3'b001}, // R5 busy
    '{3'b111, 14'b00000000010000, 1'b1, 20'h00400, 3'b011}, // R5
    '{3'b111, 14'b00000000111000, 1'b1, 20'h00300, 3'b011}, // R9
    '{3'b111, 14'b00100000000000, 1'b1, 20'h00200, 3'b010}, // R3 pin
    '{3'b011, 14'b00011000000000, 1'b1, 20'h00200, 3'b010}, // R3 tea
    '{3'b011, 14'b00010000000000, 1'b0, 20'h00000, 3'b011}, // R3 tea idle
    '{3'b111, 14'b00000100000000, 1'b1, 20'h00200, 3'b010}, // R3 ap
    '{3'b010, 14'b00000010000000, 1'b1, 20'h00200, 3'b010}, // R3 dp
    '{3'b011, 14'b00000001100000, 1'b1, 20'h00200, 3'b010}, // R9 l2p>dfl
    '{3'b111, 14'b01100000000000, 1'b1, 20'h00100, 3'b000}, // R2 srst
    '{3'b110, 14'b10000000000010, 1'b1, 20'h00100, 3'b000}, // R2 hrst
    '{3'b100, 14'b00000000000110, 1'b0, 20'h00000, 3'b100}  // R8 dec busy
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] v);
    {hrst, srst, mc, tea, dba, ap, dp, l2p, dfl, ifl, ext, dec, busy, done} = v;
  endtask

  task automatic load_state(input logic [2:0] s);
    @(negedge clk);
    drive('0); sld = 1'b1; sin = s;
    @(negedge clk);
    sld = 1'b0;
  endtask

  initial begin
    #800000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    drive('0); sld = 1'b0; sin = '0; pc = '0;
    repeat (3) @(negedge clk);
    chk("R1 take in reset", 32'(take), 0);
    chk("R1 state in reset", 32'(cst), 0);
    chk("R1 checkstop in reset", 32'(cstop), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 por take", 32'(take), 1);
    chk("R1 por vector", 32'(vec), 32'h100);
    @(negedge clk);
    chk("R1 single strobe", 32'(take), 0);

    for (int i = 0; i < NROW; i++) begin
      load_state(TBL[i].st);
      drive(TBL[i].rin);
      pc = 32'h1000 + 32'(i) * 4;
      @(negedge clk);
      chk($sformatf("R9 row%0d take", i), 32'(take), 32'(TBL[i].tk));
      chk($sformatf("R12 row%0d state", i), 32'(cst), 32'(TBL[i].nst));
      if (TBL[i].tk) begin
        chk($sformatf("R13 row%0d vector", i), 32'(vec), 32'(TBL[i].v));
        chk($sformatf("R10 row%0d saved pc", i), spc, pc);
        chk($sformatf("R10 row%0d saved state", i), 32'(sst), 32'(TBL[i].st));
      end
      drive('0);
    end

    // R4: disabled machine check halts; only reset recovers
    load_state(3'b101);
    drive(14'b00100000000000);
    @(negedge clk);
    chk("R4 no take", 32'(take), 0);
    chk("R4 checkstop set", 32'(cstop), 1);
    drive(14'b00000000101000);
    @(negedge clk);
    chk("R4 halted blocks", 32'(take), 0);
    chk("R4 checkstop held", 32'(cstop), 1);
    drive(14'b01000000000000);
    @(negedge clk);
    chk("R4 reset recovers take", 32'(take), 1);
    chk("R2 reset vector", 32'(vec), 32'h100);
    chk("R2 checkstop cleared", 32'(cstop), 0);
    drive('0);

    // R11: ext withdrawn while busy is dropped
    load_state(3'b111);
    drive(14'b00000000001010);
    repeat (3) begin
      @(negedge clk);
      chk("R11 held pending", 32'(take), 0);
    end
    drive(14'b00000000000011);
    @(negedge clk);
    chk("R11 dropped", 32'(take), 0);
    chk("R11 state kept", 32'(cst), 3'b111);
    drive('0);

    // R12: take wins over state_load
    load_state(3'b000);
    @(negedge clk);
    sld = 1'b1; sin = 3'b111; pc = 32'h2000;
    drive(14'b00000000100000);
    @(negedge clk);
    chk("R12 take wins", 32'(take), 1);
    chk("R5 dfault vector", 32'(vec), 32'h300);
    chk("R12 load ignored", 32'(cst), 3'b000);
    chk("R10 saved old state", 32'(sst), 3'b000);
    sld = 1'b0; drive('0);
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule